// File: doc/BRIEF.md
# Rolling Byte Hash Accumulator

This block folds a stream of 8-bit characters into a four-byte message summary and hands that summary to a separate signing engine. A host drives two command levels: one announces a new character, the other asks for a signature. For every character, the block adds the character to the lowest summary byte, dropping the carry. The remaining bytes then move down one place, and the sum is written into the top byte.

When a signature is requested, the block copies the summary into a held output register. It sends a one-cycle start pulse to the signing engine, lowers its done flag and clears the summary, so the next message starts from zero. The done flag rises again one cycle after the engine reports completion.

Commands are level signals. Each accepted command must fall back to the idle value before another command can be taken, so a command held high for many cycles acts only once.

Top module: `rolling_hash_acc`

## Requirements
- R1: While rst is high and on the first cycle after it, summary_out is 0, eng_start is 0 and done is 1. The summary starts at all zeros.
- R2: For each accepted character, the new top summary byte (bits 31:24) equals (old bits 7:0 + character) mod 256. The carry is discarded.
- R3: For each accepted character, old byte 1 moves to byte 0, old byte 2 to byte 1 and old byte 3 to byte 2. A one-character message c therefore yields summary {c, 0, 0, 0}.
- R4: The command is {cmd_sign, cmd_char}. Value 1 is a character and value 2 is a sign request. Once a command is accepted, nothing further is accepted until the command has been 0 for at least one clock edge, so holding a command acts only once.
- R5: Command value 3 (both bits high) is ignored: no character is added and no signature starts. It still has to return to 0 before the next command is taken.
- R6: An accepted sign request loads summary_out with the summary, drives eng_start high for exactly one cycle (the cycle after acceptance), and clears the summary to 0.
- R7: done goes low in the same cycle in which eng_start is high, and goes high one cycle after engine_done is seen while done is low.
- R8: summary_out keeps its value except when a sign request is accepted.
- R9: A sign request that arrives while done is low is ignored. The summary is kept and no start pulse is issued.
- R10: A command that is already high when reset is released is not acted on until it has returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| char_in | input | 8 | Character byte, sampled with cmd_char |
| cmd_char | input | 1 | Command bit 0: new character |
| cmd_sign | input | 1 | Command bit 1: sign request |
| engine_done | input | 1 | Completion strobe from the signing engine |
| summary_out | output | 32 | Summary latched at the last sign request |
| eng_start | output | 1 | One-cycle start pulse to the signing engine |
| done | output | 1 | High when no signature is pending |

## Verification
A command set up before a rising edge updates the internal summary at that edge. Its effect only appears at the ports after a later sign request: summary_out, eng_start and the falling done are all visible one edge after the sign request is accepted. eng_start returns low one edge after that, and done rises one edge after engine_done. The bench drives inputs on the falling edge and samples on the following falling edge, exactly one register stage after each stimulus. It compares summary_out with a byte-rotation model computed in the bench, after single-character sweeps over all 256 values and after multi-byte messages that wrap the add.

// File: rtl/rha_pkg.sv
package rha_pkg;
  localparam int BYTE_W    = 8;
  localparam int SUM_BYTES = 4;

  typedef enum logic {
    GATE_WAIT_IDLE = 1'b0,
    GATE_ARMED     = 1'b1
  } gate_state_t;

  localparam logic [1:0] CMD_NONE = 2'b00;
  localparam logic [1:0] CMD_CHAR = 2'b01;
  localparam logic [1:0] CMD_SIGN = 2'b10;
endpackage

// File: rtl/rha_cmd_gate.sv
module rha_cmd_gate
  import rha_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_char,
  input  logic cmd_sign,
  input  logic busy,
  output logic go_char,
  output logic go_sign
);
  gate_state_t state_q;
  logic [1:0]  cmd;

  assign cmd = {cmd_sign, cmd_char};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_WAIT_IDLE;
    end else begin
      case (state_q)
        GATE_WAIT_IDLE: if (cmd == CMD_NONE) state_q <= GATE_ARMED;
        GATE_ARMED:     if (cmd != CMD_NONE) state_q <= GATE_WAIT_IDLE;
        default:        state_q <= GATE_WAIT_IDLE;
      endcase
    end
  end

  // Value 3 (both bits) matches neither code and is dropped.
  assign go_char = (state_q == GATE_ARMED) && (cmd == CMD_CHAR);
  assign go_sign = (state_q == GATE_ARMED) && (cmd == CMD_SIGN) && !busy;

  // R4: an accepted command cannot be accepted again on the next edge
  p_single_shot_r4: assert property (@(posedge clk) disable iff (rst)
    (go_char || go_sign) |=> !(go_char || go_sign));
endmodule

// File: rtl/rha_rot_acc.sv
module rha_rot_acc #(
  parameter int BW = 8,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_char,
  input  logic            go_sign,
  input  logic [BW-1:0]   char_in,
  output logic [NB*BW-1:0] sum_flat
);
  logic [NB-1:0][BW-1:0] sum_q;
  logic [NB-1:0][BW-1:0] sum_step;

  genvar i;
  generate
    for (i = 0; i < NB - 1; i++) begin : g_shift
      assign sum_step[i] = sum_q[i+1];
    end
  endgenerate

  // carry out of the byte add is dropped by width truncation
  assign sum_step[NB-1] = sum_q[0] + char_in;

  always_ff @(posedge clk) begin
    if (rst || go_sign) begin
      sum_q <= '0;
    end else if (go_char) begin
      sum_q <= sum_step;
    end
  end

  assign sum_flat = sum_q;

  // R6: summary is zero after an accepted sign request
  p_clear_after_sign_r6: assert property (@(posedge clk) disable iff (rst)
    go_sign |=> (sum_q == '0));
  // R3: the lower bytes take the old upper bytes after a character
  p_rotate_r3: assert property (@(posedge clk) disable iff (rst)
    go_char |=> (sum_q[0] == $past(sum_q[1])));
endmodule

// File: rtl/rha_sign_port.sv
module rha_sign_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_sign,
  input  logic         engine_done,
  input  logic [W-1:0] sum_flat,
  output logic [W-1:0] out_q,
  output logic         start_q,
  output logic         done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b1;
    end else begin
      start_q <= go_sign;
      if (go_sign) begin
        out_q  <= sum_flat;
        done_q <= 1'b0;
      end else if (engine_done && !done_q) begin
        done_q <= 1'b1;
      end
    end
  end

  // R6: the start pulse lasts exactly one cycle
  p_start_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  // R7: done is low while start is high
  p_start_lowers_done_r7: assert property (@(posedge clk) disable iff (rst)
    start_q |-> !done_q);
  // R7: done only rises after the engine reports completion
  p_done_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(engine_done));
  // R8: the output register moves only together with a start pulse
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !start_q |-> $stable(out_q));
endmodule

// File: rtl/rolling_hash_acc.sv
module rolling_hash_acc
  import rha_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NB = SUM_BYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   char_in,
  input  logic            cmd_char,
  input  logic            cmd_sign,
  input  logic            engine_done,
  output logic [NB*BW-1:0] summary_out,
  output logic            eng_start,
  output logic            done
);
  localparam int SW = NB * BW;

  logic          go_char;
  logic          go_sign;
  logic [SW-1:0] sum_flat;

  rha_cmd_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .cmd_char (cmd_char),
    .cmd_sign (cmd_sign),
    .busy     (!done),
    .go_char  (go_char),
    .go_sign  (go_sign)
  );

  rha_rot_acc #(.BW(BW), .NB(NB)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .go_char  (go_char),
    .go_sign  (go_sign),
    .char_in  (char_in),
    .sum_flat (sum_flat)
  );

  rha_sign_port #(.W(SW)) u_port (
    .clk         (clk),
    .rst         (rst),
    .go_sign     (go_sign),
    .engine_done (engine_done),
    .sum_flat    (sum_flat),
    .out_q       (summary_out),
    .start_q     (eng_start),
    .done_q      (done)
  );

  // R5: a command with both bits set never starts a signature
  p_both_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_char && cmd_sign) |=> !eng_start);
  // R9: no start while a signature is pending
  p_busy_no_start_r9: assert property (@(posedge clk) disable iff (rst)
    (!done && !eng_start) |=> !eng_start);
endmodule

// File: tb/rolling_hash_acc_test.sv
module rolling_hash_acc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  char_in = '0;
  logic        cmd_char = 1'b0;
  logic        cmd_sign = 1'b0;
  logic        engine_done = 1'b0;
  logic [31:0] summary_out;
  logic        eng_start;
  logic        done;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  rolling_hash_acc uut (
    .clk(clk), .rst(rst), .char_in(char_in), .cmd_char(cmd_char),
    .cmd_sign(cmd_sign), .engine_done(engine_done),
    .summary_out(summary_out), .eng_start(eng_start), .done(done)
  );

  function automatic logic [31:0] step(input logic [31:0] s, input logic [7:0] c);
    logic [7:0] a;
    a = s[7:0] + c;
    return {a, s[31:8]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_char(input logic [7:0] c);
    char_in = c; cmd_char = 1'b1;
    @(negedge clk);
    cmd_char = 1'b0;
    @(negedge clk);
    model = step(model, c);
  endtask

  // sign, verify the handoff and complete the engine
  task automatic sign_msg(input string req);
    cmd_sign = 1'b1;
    @(negedge clk);
    check({req, "/R6 summary_out"}, summary_out, model);
    check("R6 eng_start high", {31'd0, eng_start}, 32'd1);
    check("R7 done low", {31'd0, done}, 32'd0);
    cmd_sign = 1'b0;
    model = '0;
    @(negedge clk);
    check("R6 eng_start one cycle", {31'd0, eng_start}, 32'd0);
    repeat (2) @(negedge clk);
    check("R7 done waits engine", {31'd0, done}, 32'd0);
    engine_done = 1'b1;
    @(negedge clk);
    engine_done = 1'b0;
    check("R7 done rises", {31'd0, done}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 summary_out reset", summary_out, 32'd0);
    check("R1 eng_start reset", {31'd0, eng_start}, 32'd0);
    check("R1 done reset", {31'd0, done}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {summary_out[31:1], eng_start, done}, 32'd1);

    // R3 / R2 sweep: every single-character message
    for (int c = 0; c < 256; c++) begin
      put_char(c[7:0]);
      sign_msg("R3");
    end

    // R2 carry drop and longer messages
    for (int len = 1; len <= 12; len++) begin
      for (int k = 0; k < len; k++) put_char(8'((k * 37 + len * 11 + 200) & 255));
      sign_msg("R2");
    end
    for (int k = 0; k < 9; k++) put_char(8'hFF);
    sign_msg("R2 all-ones");
    sign_msg("R6 empty message");

    // R4: hold a character command for many cycles
    char_in = 8'h5A; cmd_char = 1'b1;
    repeat (6) @(negedge clk);
    cmd_char = 1'b0;
    @(negedge clk);
    model = step(model, 8'h5A);
    sign_msg("R4");

    // R4: back-to-back commands without an idle gap
    char_in = 8'h11; cmd_char = 1'b1;
    @(negedge clk);
    cmd_char = 1'b0; cmd_sign = 1'b1;
    @(negedge clk);
    check("R4 no gap, no start", {31'd0, eng_start}, 32'd0);
    cmd_sign = 1'b0;
    @(negedge clk);
    model = step(model, 8'h11);
    sign_msg("R4 gap");

    // R5: both bits high is ignored
    put_char(8'h21);
    char_in = 8'h99; cmd_char = 1'b1; cmd_sign = 1'b1;
    @(negedge clk);
    check("R5 no start", {31'd0, eng_start}, 32'd0);
    check("R5 done stays", {31'd0, done}, 32'd1);
    cmd_char = 1'b0; cmd_sign = 1'b0;
    @(negedge clk);
    sign_msg("R5 summary untouched");

    // R9: sign while busy ignored, R8 output held
    put_char(8'h44);
    cmd_sign = 1'b1;
    @(negedge clk);
    cmd_sign = 1'b0;
    check("R8 first latch", summary_out, model);
    model = '0;
    @(negedge clk);
    put_char(8'h07);
    cmd_sign = 1'b1;
    @(negedge clk);
    check("R9 no start when busy", {31'd0, eng_start}, 32'd0);
    check("R8 summary_out held", summary_out, 32'h4400_0000);
    cmd_sign = 1'b0;
    @(negedge clk);
    engine_done = 1'b1;
    @(negedge clk);
    engine_done = 1'b0;
    check("R7 done after busy", {31'd0, done}, 32'd1);
    put_char(8'h03);
    check("R8 held over chars", summary_out, 32'h4400_0000);
    sign_msg("R9 summary kept");

    // R10: command held through reset release
    rst = 1'b1;
    char_in = 8'hAB; cmd_char = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    cmd_char = 1'b0;
    @(negedge clk);
    model = '0;
    sign_msg("R10");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule